// File: doc/BRIEF.md
# Processor Boot-Strap Reset Sequencer

This controller sits in an FPGA next to a processor and brings that processor out of power-on reset. It waits until the board reports good supplies and a locked reference clock. It then captures a group of configuration straps and presents them on pins that the processor samples when its resets are released. The straps are the byte order, a 13-bit boot mode, the PCIe subsystem mode, the PCIe enable and the packet-engine clock source. With the straps held, the controller releases three active-low reset lines in a fixed order, each a programmable number of cycles after the one before. The strap pins are shared with general-purpose functions on the processor. For that reason the controller stops driving them a further interval after the last release and raises a done flag.

The sequence runs through seven named states. WAIT_PWR holds every reset low and keeps the straps driven. When power-good and clock-lock are both high it moves to DRIVE_STRAP and captures the straps. Each later transition fires when the stage timer expires: DRIVE_STRAP to REL_RESET releases the warm reset, REL_RESET to REL_POR releases the power-on reset, and REL_POR to REL_FULL releases the full reset. REL_FULL moves to HOLD after one cycle, and HOLD moves to RUN, where the strap drivers turn off and done is set. From any state other than WAIT_PWR, losing power-good or clock-lock returns the machine to WAIT_PWR. The synchronous controller reset also returns it to WAIT_PWR.

Top module: `boot_strap_sequencer`

## Requirements
- R1: While `rst` is high, and in the cycle after it, all three reset lines are low, `strap_oe` is 1, `done` is 0 and `strap_out` is all zeros, so the PCIe enable strap reads disabled.
- R2: `strap_out` packs bit 0 as byte order, bits 13:1 as boot mode, bits 15:14 as PCIe mode, bit 16 as PCIe enable and bit 17 as packet-engine clock select. The PCIe mode codes are 00 endpoint, 01 legacy endpoint and 10 root complex. A requested 11 is presented as 00.
- R3: No reset line is released while `pwr_good` or `clk_locked` is low, even if the other one is high.
- R4: Let N be `STAGE_CYCLES`. The first rising clock edge with both supply inputs high starts the sequence. `warm_rst_n` rises N cycles later, `por_n` N cycles after that, and `full_rst_n` N cycles after that. The three lines are never released in any other order.
- R5: N cycles after `full_rst_n` rises, `strap_oe` falls and `done` rises in the same cycle. `done` stays high until a restart.
- R6: If `pwr_good` or `clk_locked` drops at any point, all reset lines go low and `strap_oe` goes to 1 in that same cycle, and `done` goes low. The sequence then restarts from WAIT_PWR.
- R7: Strap inputs are captured at the start of the sequence. Changes on them afterwards do not affect `strap_out`.
- R8: `strap_oe` is 1 whenever any reset line is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high controller reset |
| pwr_good | input | 1 | All supplies stable |
| clk_locked | input | 1 | Processor reference clock stable |
| cfg_byte_order | input | 1 | Requested byte-order strap |
| cfg_boot_mode | input | 13 | Requested boot-mode strap |
| cfg_pcie_mode | input | 2 | Requested PCIe subsystem mode |
| cfg_pcie_en | input | 1 | Requested PCIe enable strap |
| cfg_pkt_clk_sel | input | 1 | Requested packet-engine clock source |
| warm_rst_n | output | 1 | First reset released (active low) |
| por_n | output | 1 | Power-on reset, released second (active low) |
| full_rst_n | output | 1 | Full reset, released last (active low) |
| strap_out | output | 18 | Captured strap levels for the pin drivers |
| strap_oe | output | 1 | Strap pin output enable; 0 leaves the pins high-impedance |
| done | output | 1 | Sequence complete, strap pins released |

## Verification
The hardest case to reach is a supply drop in the middle of the sequence, after some resets have been released and others have not. A drop there has to clear the partial releases and then restart cleanly with newly captured straps. The bench shortens the stage interval, counts cycles from the starting edge, and pulls `clk_locked` low while the machine is in the REL_POR stage. It then re-raises the supply inputs with different strap inputs and checks that the new values appear and the full order is replayed. A second restart is forced by the controller reset from RUN, with the reserved PCIe mode code on the inputs.

// File: rtl/boot_seq_pkg.sv
package boot_seq_pkg;

    localparam int BOOT_W  = 13;
    localparam int MODE_W  = 2;
    localparam int STRAP_W = 1 + BOOT_W + MODE_W + 1 + 1;

    typedef enum logic [2:0] {
        WAIT_PWR,
        DRIVE_STRAP,
        REL_RESET,
        REL_POR,
        REL_FULL,
        HOLD,
        RUN
    } seq_state_e;

    typedef struct packed {
        logic              pkt_clk_sel;
        logic              pcie_en;
        logic [MODE_W-1:0] pcie_mode;
        logic [BOOT_W-1:0] boot_mode;
        logic              byte_order;
    } strap_t;

    // The reserved mode code falls back to endpoint.
    function automatic logic [MODE_W-1:0] legal_mode(input logic [MODE_W-1:0] m);
        return (m == {MODE_W{1'b1}}) ? '0 : m;
    endfunction

endpackage

// File: rtl/strap_latch.sv
module strap_latch
    import boot_seq_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   capture,
    input  strap_t raw,
    output strap_t held
);

    always_ff @(posedge clk) begin
        if (rst) begin
            held <= '0;
        end else if (capture) begin
            held           <= raw;
            held.pcie_mode <= legal_mode(raw.pcie_mode);
        end
    end

    AST_MODE_LEGAL: assert property (@(posedge clk) disable iff (rst)
        held.pcie_mode != {MODE_W{1'b1}});                          // R2

    AST_HOLD_NO_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        !capture |=> $stable(held));                                // R7

endmodule

// File: rtl/stage_timer.sv
module stage_timer #(
    parameter int LIMIT = 1024
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    output logic expired
);

    localparam int CW = (LIMIT > 2) ? $clog2(LIMIT) : 1;
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt;

    assign expired = (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt <= '0;
        end else if (!expired) begin
            cnt <= cnt + 1'b1;
        end
    end

    initial begin
        AST_LIMIT_MIN: assert (LIMIT >= 2);                         // R4
    end

    AST_TIMER_RANGE: assert property (@(posedge clk) disable iff (rst)
        cnt <= LAST);                                               // R4

endmodule

// File: rtl/boot_strap_sequencer.sv
module boot_strap_sequencer
    import boot_seq_pkg::*;
#(
    parameter int STAGE_CYCLES = 1024
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               pwr_good,
    input  logic               clk_locked,
    input  logic               cfg_byte_order,
    input  logic [BOOT_W-1:0]  cfg_boot_mode,
    input  logic [MODE_W-1:0]  cfg_pcie_mode,
    input  logic               cfg_pcie_en,
    input  logic               cfg_pkt_clk_sel,
    output logic               warm_rst_n,
    output logic               por_n,
    output logic               full_rst_n,
    output logic [STRAP_W-1:0] strap_out,
    output logic               strap_oe,
    output logic               done
);

    seq_state_e state_q, state_n;
    logic       supply_ok;
    logic       stage_done;
    logic       timer_clear;
    logic       capture;
    strap_t     raw_straps, held_straps;
    logic       rel_warm, rel_por, rel_full, in_run;

    assign supply_ok = pwr_good && clk_locked;
    assign capture   = (state_q == WAIT_PWR) && supply_ok;

    assign raw_straps = '{pkt_clk_sel: cfg_pkt_clk_sel,
                          pcie_en:     cfg_pcie_en,
                          pcie_mode:   cfg_pcie_mode,
                          boot_mode:   cfg_boot_mode,
                          byte_order:  cfg_byte_order};

    strap_latch u_latch (
        .clk     (clk),
        .rst     (rst),
        .capture (capture),
        .raw     (raw_straps),
        .held    (held_straps)
    );

    stage_timer #(.LIMIT(STAGE_CYCLES)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .clear   (timer_clear),
        .expired (stage_done)
    );

    // Next-state selection
    always_comb begin
        state_n = state_q;
        unique case (state_q)
            WAIT_PWR:    if (supply_ok)  state_n = DRIVE_STRAP;
            DRIVE_STRAP: if (stage_done) state_n = REL_RESET;
            REL_RESET:   if (stage_done) state_n = REL_POR;
            REL_POR:     if (stage_done) state_n = REL_FULL;
            REL_FULL:                    state_n = HOLD;
            HOLD:        if (stage_done) state_n = RUN;
            RUN:                         state_n = RUN;
            default:                     state_n = WAIT_PWR;
        endcase
        if (state_q != WAIT_PWR && !supply_ok) begin
            state_n = WAIT_PWR;
        end
    end

    // REL_FULL counts as the first cycle of the final interval.
    assign timer_clear = (state_n != state_q) &&
                         !(state_q == REL_FULL && state_n == HOLD);

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= WAIT_PWR;
        end else begin
            state_q <= state_n;
        end
    end

    // Output decode
    always_comb begin
        rel_warm = 1'b0;
        rel_por  = 1'b0;
        rel_full = 1'b0;
        in_run   = 1'b0;
        unique case (state_q)
            WAIT_PWR, DRIVE_STRAP: ;
            REL_RESET: rel_warm = 1'b1;
            REL_POR: begin
                rel_warm = 1'b1;
                rel_por  = 1'b1;
            end
            REL_FULL, HOLD: begin
                rel_warm = 1'b1;
                rel_por  = 1'b1;
                rel_full = 1'b1;
            end
            RUN: begin
                rel_warm = 1'b1;
                rel_por  = 1'b1;
                rel_full = 1'b1;
                in_run   = 1'b1;
            end
            default: ;
        endcase
    end

    // A supply loss forces the pins back at once, before the state register follows.
    assign warm_rst_n = rel_warm && supply_ok;
    assign por_n      = rel_por  && supply_ok;
    assign full_rst_n = rel_full && supply_ok;
    assign done       = in_run   && supply_ok;
    assign strap_oe   = !(in_run && supply_ok);
    assign strap_out  = held_straps;

    AST_RESET_ORDER: assert property (@(posedge clk) disable iff (rst)
        (!por_n || warm_rst_n) && (!full_rst_n || por_n));          // R4

    AST_START_GATED: assert property (@(posedge clk) disable iff (rst)
        (state_q == WAIT_PWR && !supply_ok) |=> (state_q == WAIT_PWR)); // R3

    AST_DONE_AFTER_FULL: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> $past(full_rst_n));                         // R5

    AST_DROP_RESTART: assert property (@(posedge clk) disable iff (rst)
        (state_q != WAIT_PWR && !supply_ok) |=> (state_q == WAIT_PWR)); // R6

    AST_STRAP_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (state_q != WAIT_PWR && $past(state_q) != WAIT_PWR) |-> $stable(strap_out)); // R7

    AST_DRIVE_IN_RESET: assert property (@(posedge clk) disable iff (rst)
        (!warm_rst_n || !por_n || !full_rst_n) |-> strap_oe);       // R8

endmodule

// File: tb/boot_strap_sequencer_tb_top.sv
`timescale 1ns/1ps
module boot_strap_sequencer_tb_top;

    localparam int N = 6;

    logic        clk = 1'b0;
    logic        rst;
    logic        pwr_good, clk_locked;
    logic        cfg_byte_order, cfg_pcie_en, cfg_pkt_clk_sel;
    logic [12:0] cfg_boot_mode;
    logic [1:0]  cfg_pcie_mode;
    logic        warm_rst_n, por_n, full_rst_n, strap_oe, done;
    logic [17:0] strap_out;

    always #2 clk = ~clk;

    boot_strap_sequencer #(.STAGE_CYCLES(N)) dut_i (
        .clk             (clk),
        .rst             (rst),
        .pwr_good        (pwr_good),
        .clk_locked      (clk_locked),
        .cfg_byte_order  (cfg_byte_order),
        .cfg_boot_mode   (cfg_boot_mode),
        .cfg_pcie_mode   (cfg_pcie_mode),
        .cfg_pcie_en     (cfg_pcie_en),
        .cfg_pkt_clk_sel (cfg_pkt_clk_sel),
        .warm_rst_n      (warm_rst_n),
        .por_n           (por_n),
        .full_rst_n      (full_rst_n),
        .strap_out       (strap_out),
        .strap_oe        (strap_oe),
        .done            (done)
    );

    int cyc = 0;
    int checks = 0;
    int errors = 0;

    always @(posedge clk) cyc <= cyc + 1;

    // ctl = {warm_rst_n, por_n, full_rst_n, strap_oe, done}
    localparam logic [4:0] C_HELD = 5'b00010;
    localparam logic [4:0] C_WARM = 5'b10010;
    localparam logic [4:0] C_POR  = 5'b11010;
    localparam logic [4:0] C_FULL = 5'b11110;
    localparam logic [4:0] C_RUN  = 5'b11101;

    typedef struct {
        int          at;
        logic [4:0]  ctl;
        logic        chk_strap;
        logic [17:0] straps;
        string       req;
    } exp_t;

    exp_t sb[$];

    task automatic push(input int at, input logic [4:0] ctl, input logic cs,
                        input logic [17:0] s, input string req);
        exp_t e;
        e.at = at; e.ctl = ctl; e.chk_strap = cs; e.straps = s; e.req = req;
        sb.push_back(e);
    endtask

    // Monitor: compare outputs against queued expectations
    always @(negedge clk) begin
        exp_t e;
        logic [4:0] act;
        while (sb.size() > 0 && sb[0].at <= cyc) begin
            e = sb.pop_front();
            act = {warm_rst_n, por_n, full_rst_n, strap_oe, done};
            checks++;
            if (act !== e.ctl) begin
                errors++;
                $display("FAIL %s cycle %0d: ctl actual %b expected %b", e.req, cyc, act, e.ctl);
            end
            if (e.chk_strap) begin
                checks++;
                if (strap_out !== e.straps) begin
                    errors++;
                    $display("FAIL %s cycle %0d: straps actual %h expected %h",
                             e.req, cyc, strap_out, e.straps);
                end
            end
        end
    end

    function automatic logic [17:0] pack(input logic bo, input logic [12:0] bm,
                                         input logic [1:0] md, input logic en, input logic pk);
        logic [1:0] m;
        m = (md == 2'b11) ? 2'b00 : md;   // R2 reserved code shows as endpoint
        return {pk, en, m, bm, bo};
    endfunction

    task automatic set_cfg(input logic bo, input logic [12:0] bm, input logic [1:0] md,
                           input logic en, input logic pk);
        cfg_byte_order = bo; cfg_boot_mode = bm; cfg_pcie_mode = md;
        cfg_pcie_en = en; cfg_pkt_clk_sel = pk;
    endtask

    task automatic drain();
        while (sb.size() > 0) @(negedge clk);
    endtask

    // Called at a negedge where supplies are (or just became) good in WAIT_PWR.
    task automatic full_seq(input logic [17:0] s, input bit scramble);
        int c0;
        c0 = cyc;
        push(c0 + 1,       C_HELD, 1, s, "R2");
        push(c0 + N,       C_HELD, 1, s, "R4 before warm");
        push(c0 + N + 1,   C_WARM, 1, s, "R4 warm first R8");
        push(c0 + 2*N,     C_WARM, 0, s, "R4 before por");
        push(c0 + 2*N + 1, C_POR,  1, s, "R4 por second R7");
        push(c0 + 3*N,     C_POR,  0, s, "R4 before full");
        push(c0 + 3*N + 1, C_FULL, 1, s, "R4 full last R8");
        push(c0 + 4*N,     C_FULL, 1, s, "R5 still driven");
        push(c0 + 4*N + 1, C_RUN,  0, s, "R5 release and done");
        push(c0 + 4*N + 6, C_RUN,  0, s, "R5 done held");
        if (scramble) begin
            repeat (2) @(negedge clk);
            set_cfg(~s[0], ~s[13:1], 2'b01, ~s[16], ~s[17]);   // R7
        end
        drain();
    endtask

    initial begin : driver
        int c0;
        rst = 1'b1; pwr_good = 1'b0; clk_locked = 1'b0;
        set_cfg(1'b1, 13'h0A5B, 2'b01, 1'b1, 1'b1);
        repeat (3) @(negedge clk);
        push(cyc + 1, C_HELD, 1, 18'h0, "R1 in reset");
        @(negedge clk);
        rst = 1'b0;
        push(cyc + 1, C_HELD, 1, 18'h0, "R1 after reset");
        drain();

        // R3: one good input alone does not start anything
        pwr_good = 1'b1;
        push(cyc + N + 4, C_HELD, 0, 18'h0, "R3 lock low");
        drain();
        pwr_good = 1'b0; clk_locked = 1'b1;
        push(cyc + N + 4, C_HELD, 0, 18'h0, "R3 power low");
        drain();

        // Full sequence with inputs changed midway
        pwr_good = 1'b1;
        full_seq(pack(1'b1, 13'h0A5B, 2'b01, 1'b1, 1'b1), 1'b1);

        // Controller reset from RUN, reserved mode on inputs
        set_cfg(1'b0, 13'h1234, 2'b11, 1'b0, 1'b1);
        rst = 1'b1;
        push(cyc + 1, C_HELD, 1, 18'h0, "R1 reset from run");
        drain();
        rst = 1'b0;
        full_seq(pack(1'b0, 13'h1234, 2'b11, 1'b0, 1'b1), 1'b0);

        // R6: lock lost during REL_POR
        pwr_good = 1'b0;
        @(negedge clk);
        push(cyc + 1, C_HELD, 0, 18'h0, "R6 supply lost after run");
        drain();
        set_cfg(1'b1, 13'h1FFF, 2'b10, 1'b1, 1'b0);
        pwr_good = 1'b1;
        c0 = cyc;
        push(c0 + 2*N + 1, C_POR, 0, 18'h0, "R4 partial por");
        while (cyc < c0 + 2*N + 3) @(negedge clk);
        clk_locked = 1'b0;
        push(cyc + 1, C_HELD, 0, 18'h0, "R6 drop clears resets");
        push(cyc + 4, C_HELD, 0, 18'h0, "R6 stays waiting");
        drain();
        set_cfg(1'b0, 13'h0F0F, 2'b10, 1'b1, 1'b0);
        clk_locked = 1'b1;
        full_seq(pack(1'b0, 13'h0F0F, 2'b10, 1'b1, 1'b0), 1'b0);

        finish_run();
    end

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

endmodule